// File: doc/BRIEF.md
# SIMD Lane Predicate Mask Stack

This block keeps track of which of a wavefront's vector lanes are enabled while a sequencer walks through nested structured if/else/endif regions. A command port carries one command per cycle: open a conditional region with a per-lane condition vector, switch to the alternate branch, close the region, or discard lanes. The block holds the live lane mask and a bounded stack of saved masks, with one entry for each open region.

Each stack entry stores only the lanes that the current branch has switched off. Opening a region narrows the mask and saves the lanes that were live but failed the condition. Switching branches swaps the saved lanes with the live ones. Closing a region merges the saved lanes back in. An all-off flag lets the sequencer skip a region in which no lane is active. Stack misuse is reported with overflow and underflow pulses. In pixel mode, closing the outermost region with no live lane left raises a one-cycle request to export to the null target and end the program.

Top module: `lane_mask_stack`

## Requirements
- R1: After synchronous reset the lane mask is all ones, the stack is empty, and `lanes_off`, `overflow`, `underflow` and `term_req` are low.
- R2: An accepted IF command (`cmd_op` = 2'd1) sets the lane mask to `cond` AND the previous mask, and pushes the lanes that were live but failed `cond`.
- R3: An ELSE command (`cmd_op` = 2'd2) with a non-empty stack makes the lane mask equal to the lanes saved by the innermost IF, and saves the then-branch mask in their place.
- R4: An ENDIF command (`cmd_op` = 2'd3) with a non-empty stack ORs the innermost saved entry into the lane mask and pops it. Correctly nested regions therefore restore the mask seen before the matching IF, apart from lanes that were discarded.
- R5: A DISCARD command (`cmd_op` = 2'd0) clears from the lane mask every lane whose `cond` bit is set. The stack is not changed.
- R6: `lanes_off` is high exactly when the registered lane mask is all zeros, and it changes in the same cycle as `exec_mask`.
- R7: An IF received while `DEPTH` regions are open raises `overflow` for one cycle and changes neither the mask nor the stack.
- R8: ELSE or ENDIF with an empty stack raises `underflow` for one cycle and changes neither the mask nor the stack.
- R9: With `pixel_mode` high, an ENDIF that empties the stack and leaves an all-zero mask raises `term_req` for exactly one cycle. During that cycle `term_target` shows 4'h9. At all other times `term_target` is 4'h0.
- R10: `term_req` stays low when `pixel_mode` is low, when the resulting mask is non-zero, or when regions remain open.
- R11: Every command takes effect on the clock edge that samples it, and all outputs are registered. While `cmd_valid` is low the outputs keep their values, except that the error and terminate pulses return low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 discard, 1 if, 2 else, 3 endif |
| cond | input | LANES | Per-lane condition (IF) or discard set (DISCARD) |
| pixel_mode | input | 1 | Enables the terminate request |
| exec_mask | output | LANES | Current lane enable mask |
| lanes_off | output | 1 | Mask is all zeros |
| overflow | output | 1 | IF rejected because the stack is full (pulse) |
| underflow | output | 1 | ELSE/ENDIF rejected because the stack is empty (pulse) |
| term_req | output | 1 | Null export and program end request (pulse) |
| term_target | output | 4 | Export target code, 9 while term_req is high |

## Verification
The bench applies directed sequences first. These are a single region with a split condition, conditions that pass or fail on every lane (which separate AND from OR errors and exercise the all-off flag), and three nested levels, which show whether saved entries are kept apart by depth. The stack is then driven to exactly `DEPTH` and one past it, and ELSE/ENDIF are issued at an empty stack, which isolates the boundary compares. Discards before an outermost ENDIF, with pixel mode both high and low, distinguish the terminate condition from its near misses. A long random mix of all commands with idle cycles checks every output against a queue model on every clock.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_DISCARD = 2'd0,
    OP_IF      = 2'd1,
    OP_ELSE    = 2'd2,
    OP_ENDIF   = 2'd3
  } lms_op_e;

  localparam logic [3:0] NULL_TARGET = 4'h9;
endpackage

// File: rtl/lms_stack.sv
// Saved-mask stack: synchronous write, no reset on storage, top read combinationally.
module lms_stack #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic                           pop,
  input  logic                           repl,
  input  logic [W-1:0]                   wr_data,
  output logic [W-1:0]                   top,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] top_idx;
  logic [AW-1:0] wr_idx;

  assign top_idx = AW'(count - CW'(1));
  assign wr_idx  = push ? AW'(count) : top_idx;
  assign top     = mem[top_idx];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push || repl) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (push) count <= count + CW'(1);
    else if (pop)  count <= count - CW'(1);
  end
endmodule

// File: rtl/lms_mask_alu.sv
// Candidate next masks for every command, all derived from the live mask.
module lms_mask_alu #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] cond,
  input  logic [W-1:0] saved,
  output logic [W-1:0] if_mask,
  output logic [W-1:0] if_save,
  output logic [W-1:0] else_mask,
  output logic [W-1:0] endif_mask,
  output logic [W-1:0] kill_mask
);
  always_comb begin
    if_mask    = cur & cond;
    if_save    = cur ^ if_mask;
    else_mask  = (saved | cur) ^ cur;
    endif_mask = cur | saved;
    kill_mask  = cur & ~cond;
  end
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int LANES = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LANES-1:0] cond,
  input  logic             pixel_mode,
  output logic [LANES-1:0] exec_mask,
  output logic             lanes_off,
  output logic             overflow,
  output logic             underflow,
  output logic             term_req,
  output logic [3:0]       term_target
);
  import lms_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  logic             is_if, is_else, is_endif, is_kill;
  logic             do_push, do_repl, do_pop;
  logic [LANES-1:0] top, wr_data;
  logic [CW-1:0]    count;
  logic             empty, full;
  logic [LANES-1:0] if_mask, if_save, else_mask, endif_mask, kill_mask;
  logic [LANES-1:0] next_mask;
  logic             term_next;

  assign is_if    = cmd_valid && (cmd_op == OP_IF);
  assign is_else  = cmd_valid && (cmd_op == OP_ELSE);
  assign is_endif = cmd_valid && (cmd_op == OP_ENDIF);
  assign is_kill  = cmd_valid && (cmd_op == OP_DISCARD);

  assign do_push = is_if && !full;
  assign do_repl = is_else && !empty;
  assign do_pop  = is_endif && !empty;
  assign wr_data = do_push ? if_save : exec_mask;

  lms_stack #(.W(LANES), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push    (do_push),
    .pop     (do_pop),
    .repl    (do_repl),
    .wr_data (wr_data),
    .top     (top),
    .count   (count),
    .empty   (empty),
    .full    (full)
  );

  lms_mask_alu #(.W(LANES)) u_alu (
    .cur        (exec_mask),
    .cond       (cond),
    .saved      (top),
    .if_mask    (if_mask),
    .if_save    (if_save),
    .else_mask  (else_mask),
    .endif_mask (endif_mask),
    .kill_mask  (kill_mask)
  );

  always_comb begin
    next_mask = exec_mask;
    if (do_push)      next_mask = if_mask;
    else if (do_repl) next_mask = else_mask;
    else if (do_pop)  next_mask = endif_mask;
    else if (is_kill) next_mask = kill_mask;
  end

  assign term_next = do_pop && pixel_mode && (count == CW'(1)) && (endif_mask == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_mask   <= '1;
      lanes_off   <= 1'b0;
      overflow    <= 1'b0;
      underflow   <= 1'b0;
      term_req    <= 1'b0;
      term_target <= 4'h0;
    end else begin
      exec_mask   <= next_mask;
      lanes_off   <= (next_mask == '0);
      overflow    <= is_if && full;
      underflow   <= (is_else || is_endif) && empty;
      term_req    <= term_next;
      term_target <= term_next ? NULL_TARGET : 4'h0;
    end
  end
endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int LANES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [LANES-1:0] cond,
  input logic             pixel_mode,
  input logic [LANES-1:0] exec_mask,
  input logic             lanes_off,
  input logic             overflow,
  input logic             underflow,
  input logic             term_req,
  input logic [3:0]       term_target
);
  // R6
  lanes_off_chk: assert property (@(posedge clk) disable iff (rst)
    lanes_off == (exec_mask == '0));

  // R2
  if_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |=> ((exec_mask & ~$past(exec_mask)) == '0));

  // R5
  discard_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0) |=> ((exec_mask & $past(cond)) == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (exec_mask == $past(exec_mask)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |-> (exec_mask == $past(exec_mask)));

  // R9
  term_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    term_req |=> !term_req);

  // R9
  term_target_chk: assert property (@(posedge clk) disable iff (rst)
    term_target == (term_req ? 4'h9 : 4'h0));

  // R10
  term_cond_chk: assert property (@(posedge clk) disable iff (rst)
    term_req |-> (lanes_off && $past(pixel_mode) && $past(cmd_valid && cmd_op == 2'd3)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(exec_mask) && !overflow && !underflow && !term_req));
endmodule

bind lane_mask_stack lms_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_lane_mask_stack.sv
module test_lane_mask_stack;
  localparam int LANES = 64;
  localparam int DEPTH = 8;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [LANES-1:0] cond;
  logic             pixel_mode;
  logic [LANES-1:0] exec_mask;
  logic             lanes_off, overflow, underflow, term_req;
  logic [3:0]       term_target;

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) i_lane_mask_stack (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cond(cond),
    .pixel_mode(pixel_mode), .exec_mask(exec_mask), .lanes_off(lanes_off),
    .overflow(overflow), .underflow(underflow), .term_req(term_req),
    .term_target(term_target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk[$];
  logic             m_ov, m_un, m_term;

  function automatic logic [LANES-1:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic compare(string tag);
    logic [3:0] exp_tgt;
    exp_tgt = m_term ? 4'h9 : 4'h0;
    n_checks++;
    if (exec_mask !== m_mask || lanes_off !== (m_mask == '0) || overflow !== m_ov ||
        underflow !== m_un || term_req !== m_term || term_target !== exp_tgt) begin
      n_fail++;
      $display("FAIL %s: got mask=%h off=%b ov=%b un=%b term=%b tgt=%h exp mask=%h off=%b ov=%b un=%b term=%b tgt=%h",
               tag, exec_mask, lanes_off, overflow, underflow, term_req, term_target,
               m_mask, (m_mask == '0), m_ov, m_un, m_term, exp_tgt);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [LANES-1:0] c, bit pm, string tag);
    logic [LANES-1:0] s;
    cmd_valid = v; cmd_op = op; cond = c; pixel_mode = pm;
    @(posedge clk);
    m_ov = 0; m_un = 0; m_term = 0;
    if (v) begin
      case (op)
        2'd1: if (m_stk.size() == DEPTH) m_ov = 1;
              else begin s = m_mask & c; m_stk.push_back(m_mask ^ s); m_mask = s; end
        2'd2: if (m_stk.size() == 0) m_un = 1;
              else begin s = m_stk[$]; m_stk[$] = m_mask; m_mask = s & ~m_mask; end
        2'd3: if (m_stk.size() == 0) m_un = 1;
              else begin
                m_mask = m_mask | m_stk.pop_back();
                if (pm && m_stk.size() == 0 && m_mask == '0) m_term = 1;
              end
        default: m_mask = m_mask & ~c;
      endcase
    end
    #1;
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; cmd_valid = 0; cmd_op = 0; cond = '0; pixel_mode = 0;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    m_mask = '1; m_ov = 0; m_un = 0; m_term = 0;
    compare("R1 reset");

    // R2 R3 R4 single region with split condition
    step(1, 2'd1, 64'h0000_FFFF_0000_FFFF, 0, "R2 if split");
    step(1, 2'd2, '0, 0, "R3 else");
    step(1, 2'd3, '0, 0, "R4 endif");
    // R6 all-fail and all-pass conditions
    step(1, 2'd1, '0, 0, "R6 if all fail");
    step(1, 2'd2, '0, 0, "R6 else all lanes");
    step(1, 2'd3, '0, 0, "R4 endif restore");
    // nested three levels
    step(1, 2'd1, 64'hFF00_FF00_FF00_FF00, 0, "R2 nest1");
    step(1, 2'd1, 64'hF0F0_F0F0_F0F0_F0F0, 0, "R2 nest2");
    step(1, 2'd1, 64'hCCCC_CCCC_CCCC_CCCC, 0, "R2 nest3");
    step(1, 2'd2, '0, 0, "R3 nest3 else");
    step(1, 2'd3, '0, 0, "R4 nest3 end");
    step(1, 2'd2, '0, 0, "R3 nest2 else");
    step(1, 2'd3, '0, 0, "R4 nest2 end");
    step(1, 2'd3, '0, 0, "R4 nest1 end");
    // R11 idle cycles with garbage on cond
    step(0, 2'd0, '1, 1, "R11 idle");
    step(0, 2'd1, r64(), 1, "R11 idle");
    // R7 fill then overflow
    for (int i = 0; i < DEPTH; i++) step(1, 2'd1, r64() | r64(), 0, "R7 fill");
    step(1, 2'd1, '0, 0, "R7 overflow");
    step(1, 2'd2, '0, 0, "R7 else after overflow");
    for (int i = 0; i < DEPTH; i++) step(1, 2'd3, '0, 0, "R7 drain");
    // R8 underflow
    step(1, 2'd3, '0, 1, "R8 endif empty");
    step(1, 2'd2, '0, 1, "R8 else empty");
    // R5 discard, R9 terminate
    step(1, 2'd0, 64'h1, 0, "R5 discard one");
    step(1, 2'd1, '1, 1, "R9 open");
    step(1, 2'd0, '1, 1, "R5 discard all");
    step(1, 2'd3, '0, 1, "R9 term");
    step(0, 2'd0, '0, 1, "R9 pulse end");
    // R10 near misses
    rst = 1; @(posedge clk); #1; rst = 0; m_mask = '1; m_stk.delete();
    step(1, 2'd1, '1, 0, "R10 open");
    step(1, 2'd0, '1, 0, "R10 discard");
    step(1, 2'd3, '0, 0, "R10 no pixel");
    rst = 1; @(posedge clk); #1; rst = 0; m_mask = '1; m_stk.delete();
    step(1, 2'd1, '1, 1, "R10 open");
    step(1, 2'd1, '1, 1, "R10 open inner");
    step(1, 2'd0, '1, 1, "R10 discard");
    step(1, 2'd3, '0, 1, "R10 inner close");
    step(1, 2'd3, '0, 1, "R10 outer close zero");
    rst = 1; @(posedge clk); #1; rst = 0; m_mask = '1; m_stk.delete();
    step(1, 2'd1, '1, 1, "R10 open");
    step(1, 2'd0, 64'hF, 1, "R10 partial discard");
    step(1, 2'd3, '0, 1, "R10 nonzero close");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [LANES-1:0] c;
      k = $urandom_range(0, 9);
      c = (k == 0) ? '0 : (k == 1) ? '1 : (k < 5) ? (r64() & r64()) : r64();
      case ($urandom_range(0, 9))
        0:       step(0, 2'($urandom), c, 1'($urandom), "R11 mix idle");
        1:       step(1, 2'd0, r64() & r64() & r64(), 1'($urandom), "R5 mix");
        2, 3, 4: step(1, 2'd1, c, 1'($urandom), "R2 mix");
        5, 6:    step(1, 2'd2, c, 1'($urandom), "R3 mix");
        default: step(1, 2'd3, c, 1'($urandom), "R4 mix");
      endcase
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule